// File: doc/BRIEF.md
# Bundled-Syllable Instruction Sequencer

This block sits between an instruction memory and a stack execution unit. It fetches one 32-bit word at a time and turns it into a stream of operations. The two top bits of each word select its format. A word with bit 31 set carries one literal. The literal is issued once, as a push of the low 31 bits moved up one place with a zero in bit 0. A word whose top two bits are `00` packs five 6-bit syllables. These are handed to the execution unit one per accepted handshake, from the most significant slot to the least significant. A word whose top two bits are `01` is a reserved format. It is flagged as illegal and produces nothing.

The sequencer keeps the program counter and a syllable counter. Together they name the next operation. It accepts a redirect from the execution unit for jumps and taken branches, and it stops for good when a halt syllable has been handed over. The memory side is a one-cycle request pulse with a response that may come any number of cycles later. The issue side is a valid/ready pair.

Top module: `bsq_sequencer`

## Requirements
- R1: During and right after reset, the block asserts a fetch request for address `RESET_PC` (0 by default), offers no operation, and shows `sc` = 0, `halted` = 0 and `illegal` = 0.
- R2: A fetched word with bit 31 = 1 is offered exactly once with `iss_is_imm` = 1 and `iss_imm` = {word[30:0], 0}. For example, 0xC0404040 gives 0x80808080. While it is offered, `sc` = 0 and `pc` = word address + 4.
- R3: A fetched word with bits 31:30 = `00` is offered as syllables taken from bits 29:24, 23:18, 17:12, 11:6 and 5:0, in that order, with `iss_is_imm` = 0. Each syllable is offered until the execution unit accepts it.
- R4: While a syllable from slot k (k = 0 for bits 29:24, up to k = 4 for bits 5:0) of the word at address A is offered, `pc` = A + 4 and `sc` = (k + 1) mod 5. For example, the middle syllable of the word at 0x200 shows `pc` = 0x204 and `sc` = 3. `sc` never exceeds 4.
- R5: Syllable `000001` (no-operation) is never offered. It uses one cycle of its slot, and sequencing then moves to the next slot.
- R6: While an offered operation is not accepted (`iss_ready` = 0), it stays offered with unchanged `iss_syl`, `iss_imm` and `iss_is_imm` in the next cycle, unless that cycle carries a redirect.
- R7: A fetch request lasts one cycle, and only one request is outstanding at a time. After the last slot of a syllable word, or after a literal word, has been consumed, the next request goes to the previous request address + 4.
- R8: In a cycle with `redir_valid` = 1 no operation is offered. The next fetch request goes to `redir_addr`. Syllables still pending from the current word, and a response still in flight, are discarded. Issue then restarts at slot 0 of the target word.
- R9: A fetched word with bits 31:30 = `01` sets `illegal`. Nothing is offered and no fetch is requested until a redirect, which clears `illegal` and fetches the target.
- R10: Syllable `000000` (halt) is offered like any other syllable. Once it has been accepted, `halted` = 1 and stays 1 until reset. No further operation is offered, no fetch is requested, and redirects are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_req_valid | output | 1 | One-cycle fetch request |
| imem_req_addr | output | 32 | Byte address of the requested word |
| imem_rsp_valid | input | 1 | Fetched word is present this cycle |
| imem_rsp_data | input | 32 | Fetched instruction word |
| iss_valid | output | 1 | An operation is offered |
| iss_ready | input | 1 | Execution unit accepts the offered operation |
| iss_is_imm | output | 1 | Offered operation is a literal push |
| iss_syl | output | 6 | Offered syllable (zero for a literal) |
| iss_imm | output | 32 | Offered literal value (zero for a syllable) |
| redir_valid | input | 1 | Redirect to a new word address |
| redir_addr | input | 32 | Redirect target byte address |
| pc | output | 32 | Program counter |
| sc | output | 3 | Syllable counter, 0 to 4 |
| halted | output | 1 | Halt syllable has been accepted |
| illegal | output | 1 | Reserved-format word was fetched |

## Verification
A fetched word is captured at the edge where `imem_rsp_valid` is high, so its first operation appears in the half cycle after that edge. A handshake seen when outputs are sampled just after a falling edge completes at the next rising edge. A redirect driven at a falling edge blocks the offer at once and produces the new request one edge later. `halted` and `illegal` rise one edge after the halt handshake or the reserved word's capture. The bench drives inputs at falling edges, samples 1 ns later, and logs a handshake only when valid and ready are both seen at that point. A bench model walks the same memory image to predict each operation together with its `pc` and `sc`. Fetch addresses and stall stability are checked at the falling edge that follows the cycle concerned.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SLOT_W = 6;
    localparam int unsigned SLOTS  = 5;

    typedef enum logic [2:0] {
        ST_REQ,
        ST_WAIT,
        ST_DRAIN,
        ST_SYL,
        ST_LIT,
        ST_HALT,
        ST_ILL
    } seq_state_e;

    typedef enum logic [1:0] {
        FMT_LIT,
        FMT_RSV,
        FMT_SYL
    } word_fmt_e;

endpackage

// File: rtl/bsq_classify.sv
module bsq_classify
    import bsq_pkg::*;
#(
    parameter int unsigned WORD_W = bsq_pkg::WORD_W
) (
    input  logic [WORD_W-1:0] word,
    output word_fmt_e         fmt,
    output logic [WORD_W-1:0] lit
);

    always_comb begin
        if (word[WORD_W-1]) begin
            fmt = FMT_LIT;
        end else if (word[WORD_W-2]) begin
            fmt = FMT_RSV;
        end else begin
            fmt = FMT_SYL;
        end
        lit = {word[WORD_W-2:0], 1'b0};
    end

endmodule

// File: rtl/bsq_slot_pick.sv
module bsq_slot_pick #(
    parameter int unsigned SLOT_W = 6,
    parameter int unsigned SLOTS  = 5,
    parameter int unsigned IDX_W  = $clog2(SLOTS),
    localparam int unsigned PAY_W = SLOT_W * SLOTS
) (
    input  logic [PAY_W-1:0]  payload,
    input  logic [IDX_W-1:0]  idx,
    output logic [SLOT_W-1:0] syl
);

    logic [SLOT_W-1:0] slot_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_arr[g] = payload[PAY_W-1-g*SLOT_W -: SLOT_W];
    end

    always_comb begin
        syl = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (idx == IDX_W'(i)) begin
                syl = slot_arr[i];
            end
        end
    end

endmodule

// File: rtl/bsq_sequencer.sv
module bsq_sequencer
    import bsq_pkg::*;
#(
    parameter int unsigned WORD_W   = bsq_pkg::WORD_W,
    parameter int unsigned SLOT_W   = bsq_pkg::SLOT_W,
    parameter int unsigned SLOTS    = bsq_pkg::SLOTS,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    localparam int unsigned IDX_W   = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              imem_req_valid,
    output logic [WORD_W-1:0] imem_req_addr,
    input  logic              imem_rsp_valid,
    input  logic [WORD_W-1:0] imem_rsp_data,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic              iss_is_imm,
    output logic [SLOT_W-1:0] iss_syl,
    output logic [WORD_W-1:0] iss_imm,
    input  logic              redir_valid,
    input  logic [WORD_W-1:0] redir_addr,
    output logic [WORD_W-1:0] pc,
    output logic [IDX_W-1:0]  sc,
    output logic              halted,
    output logic              illegal
);

    localparam int unsigned       PAY_W    = SLOT_W * SLOTS;
    localparam logic [WORD_W-1:0] PC_STEP  = WORD_W'(WORD_W / 8);
    localparam logic [SLOT_W-1:0] OP_HALT  = '0;
    localparam logic [SLOT_W-1:0] OP_NOP   = SLOT_W'(1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    seq_t q, d;

    word_fmt_e         rsp_fmt;
    logic [WORD_W-1:0] rsp_lit;
    logic [SLOT_W-1:0] cur_syl;
    logic              offer;
    logic              in_flight;

    bsq_classify #(
        .WORD_W (WORD_W)
    ) i_classify (
        .word (imem_rsp_data),
        .fmt  (rsp_fmt),
        .lit  (rsp_lit)
    );

    bsq_slot_pick #(
        .SLOT_W (SLOT_W),
        .SLOTS  (SLOTS),
        .IDX_W  (IDX_W)
    ) i_slot_pick (
        .payload (q.word[PAY_W-1:0]),
        .idx     (q.idx),
        .syl     (cur_syl)
    );

    always_comb begin
        d     = q;
        offer = 1'b0;
        case (q.st)
            ST_REQ: begin
                d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (imem_rsp_valid) begin
                    d.pc  = q.pc + PC_STEP;
                    d.idx = '0;
                    case (rsp_fmt)
                        FMT_LIT: begin
                            d.st   = ST_LIT;
                            d.word = rsp_lit;
                        end
                        FMT_RSV: begin
                            d.st   = ST_ILL;
                            d.word = imem_rsp_data;
                        end
                        default: begin
                            d.st   = ST_SYL;
                            d.word = imem_rsp_data;
                        end
                    endcase
                end
            end
            ST_DRAIN: begin
                if (imem_rsp_valid) begin
                    d.st = ST_REQ;
                end
            end
            ST_SYL: begin
                offer = (cur_syl != OP_NOP);
                if (!offer || iss_ready) begin
                    if (offer && (cur_syl == OP_HALT)) begin
                        d.st = ST_HALT;
                    end else if (q.idx == LAST_IDX) begin
                        d.st  = ST_REQ;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_LIT: begin
                offer = 1'b1;
                if (iss_ready) begin
                    d.st = ST_REQ;
                end
            end
            default: begin
            end
        endcase

        in_flight = (q.st == ST_REQ)
                 || (((q.st == ST_WAIT) || (q.st == ST_DRAIN)) && !imem_rsp_valid);

        if (redir_valid && (q.st != ST_HALT)) begin
            d.pc  = redir_addr;
            d.idx = '0;
            d.st  = in_flight ? ST_DRAIN : ST_REQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_REQ;
            q.pc   <= RESET_PC;
            q.word <= '0;
            q.idx  <= '0;
        end else begin
            q <= d;
        end
    end

    assign imem_req_valid = (q.st == ST_REQ);
    assign imem_req_addr  = q.pc;
    assign iss_valid      = offer && !redir_valid;
    assign iss_is_imm     = (q.st == ST_LIT);
    assign iss_syl        = (q.st == ST_SYL) ? cur_syl : '0;
    assign iss_imm        = (q.st == ST_LIT) ? q.word : '0;
    assign pc             = q.pc;
    assign sc             = ((q.st == ST_SYL) && (q.idx != LAST_IDX)) ? (q.idx + IDX_W'(1)) : '0;
    assign halted         = (q.st == ST_HALT);
    assign illegal        = (q.st == ST_ILL);

endmodule

// File: rtl/bsq_sequencer_chk.sv
module bsq_sequencer_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SLOT_W = 6,
    parameter int unsigned SLOTS  = 5,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              imem_req_valid,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              iss_is_imm,
    input logic [SLOT_W-1:0] iss_syl,
    input logic [WORD_W-1:0] iss_imm,
    input logic              redir_valid,
    input logic [IDX_W-1:0]  sc,
    input logic              halted,
    input logic              illegal
);

    // R2: a literal always has a clear low bit and a zero syllable counter
    a_r2_literal_form: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_is_imm) |-> (!iss_imm[0] && (sc == '0)));

    // R4: syllable counter stays inside 0..SLOTS-1
    a_r4_sc_range: assert property (@(posedge clk) disable iff (!rst_n)
        sc < IDX_W'(SLOTS));

    // R5: the no-operation code is never handed over
    a_r5_no_nop_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_is_imm) |-> (iss_syl != SLOT_W'(1)));

    // R6: a stalled offer is held unchanged
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (redir_valid
            || (iss_valid && $stable(iss_syl) && $stable(iss_imm) && $stable(iss_is_imm))));

    // R7: a fetch request is a single-cycle pulse
    a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req_valid |=> !imem_req_valid);

    // R8: nothing is offered in a redirect cycle
    a_r8_redirect_squash: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !iss_valid);

    // R9: an illegal word silences both ports
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!iss_valid && !imem_req_valid));

    // R10: halt is sticky and silences both ports
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!iss_valid && !imem_req_valid));

endmodule

bind bsq_sequencer bsq_sequencer_chk #(
    .WORD_W (WORD_W),
    .SLOT_W (SLOT_W),
    .SLOTS  (SLOTS),
    .IDX_W  (IDX_W)
) i_bsq_sequencer_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .imem_req_valid (imem_req_valid),
    .iss_valid      (iss_valid),
    .iss_ready      (iss_ready),
    .iss_is_imm     (iss_is_imm),
    .iss_syl        (iss_syl),
    .iss_imm        (iss_imm),
    .redir_valid    (redir_valid),
    .sc             (sc),
    .halted         (halted),
    .illegal        (illegal)
);

// File: tb/test_bsq_sequencer.sv
`timescale 1ns/1ps
module test_bsq_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_req_valid;
    logic [31:0] imem_req_addr;
    logic        imem_rsp_valid;
    logic [31:0] imem_rsp_data;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic        iss_is_imm;
    logic [5:0]  iss_syl;
    logic [31:0] iss_imm;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_addr = '0;
    logic [31:0] pc;
    logic [2:0]  sc;
    logic        halted;
    logic        illegal;

    always #2 clk = ~clk;

    bsq_sequencer i_bsq_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .imem_req_valid (imem_req_valid),
        .imem_req_addr  (imem_req_addr),
        .imem_rsp_valid (imem_rsp_valid),
        .imem_rsp_data  (imem_rsp_data),
        .iss_valid      (iss_valid),
        .iss_ready      (iss_ready),
        .iss_is_imm     (iss_is_imm),
        .iss_syl        (iss_syl),
        .iss_imm        (iss_imm),
        .redir_valid    (redir_valid),
        .redir_addr     (redir_addr),
        .pc             (pc),
        .sc             (sc),
        .halted         (halted),
        .illegal        (illegal)
    );

    logic [31:0] mem [0:1023];

    int          n_chk = 0;
    int          n_fail = 0;
    int          n_hs = 0;
    int          cycles = 0;
    bit          finished = 1'b0;

    logic [31:0] m_addr = '0;
    int          m_k = 0;
    bit          m_halt = 1'b0;
    logic [31:0] exp_req = '0;

    bit          prev_stall = 1'b0;
    logic [5:0]  prev_syl;
    logic [31:0] prev_imm;
    logic        prev_is_imm;

    bit          probe_on = 1'b0;
    int          probe_cnt = 0;

    bit          pend = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] gen_word();
        logic [31:0] w;
        if (($urandom % 8) < 2) begin
            w = {1'b1, 31'($urandom)};
        end else begin
            w = '0;
            for (int i = 0; i < 5; i++) begin
                logic [5:0] s;
                s = 6'($urandom);
                if (($urandom % 6) == 0) s = 6'b000001;
                if (s == 6'b000000) s = 6'b101100;
                w = w | (32'(s) << (24 - 6 * i));
            end
        end
        return w;
    endfunction

    // walk the memory image and return the next operation the block must offer
    task automatic model_next(output bit e_imm_f, output logic [5:0] e_syl, output logic [31:0] e_imm,
                              output logic [31:0] e_pc, output logic [2:0] e_sc);
        bit found = 1'b0;
        int guard = 0;
        e_imm_f = 1'b0; e_syl = '0; e_imm = '0; e_pc = '0; e_sc = '0;
        while (!found && guard < 5000) begin
            logic [31:0] w;
            guard++;
            w = mem[m_addr[11:2]];
            if (w[31]) begin
                e_imm_f = 1'b1;
                e_imm   = {w[30:0], 1'b0};
                e_pc    = m_addr + 32'd4;
                e_sc    = 3'd0;
                m_addr  = m_addr + 32'd4;
                m_k     = 0;
                found   = 1'b1;
            end else begin
                logic [5:0]  s;
                logic [31:0] wpc;
                int          k;
                k   = m_k;
                s   = 6'(w >> (24 - 6 * k));
                wpc = m_addr + 32'd4;
                m_k++;
                if (m_k == 5) begin
                    m_addr = m_addr + 32'd4;
                    m_k    = 0;
                end
                if (s != 6'b000001) begin
                    e_syl = s;
                    e_pc  = wpc;
                    e_sc  = (k == 4) ? 3'd0 : 3'(k + 1);
                    found = 1'b1;
                    if (s == 6'b000000) m_halt = 1'b1;
                end
            end
        end
    endtask

    task automatic step(input bit rdy, input bit rv, input logic [31:0] ra);
        @(negedge clk);
        // R7: request addresses follow +4 except after a redirect
        if (imem_req_valid) begin
            chk(imem_req_addr == exp_req, "R7 fetch address", imem_req_addr, exp_req);
            exp_req = exp_req + 32'd4;
        end
        iss_ready   = rdy;
        redir_valid = rv;
        redir_addr  = ra;
        if (rv && !m_halt) begin
            exp_req   = ra;
            m_addr    = ra;
            m_k       = 0;
            probe_cnt = 0;
        end
        #1;
        if (prev_stall && !rv) begin
            chk(iss_valid && (iss_syl == prev_syl) && (iss_imm == prev_imm) && (iss_is_imm == prev_is_imm),
                "R6 stalled offer held", {iss_valid, iss_is_imm, iss_syl, iss_imm[23:0]},
                {1'b1, prev_is_imm, prev_syl, prev_imm[23:0]});
        end
        if (rv) chk(!iss_valid, "R8 offer squashed on redirect", 32'(iss_valid), 32'd0);
        if (iss_valid && iss_ready) begin
            bit          e_imm_f;
            logic [5:0]  e_syl;
            logic [31:0] e_imm;
            logic [31:0] e_pc;
            logic [2:0]  e_sc;
            bit          was_halted;
            was_halted = m_halt;
            chk(!was_halted, "R10 offer after halt", 32'(iss_valid), 32'd0);
            model_next(e_imm_f, e_syl, e_imm, e_pc, e_sc);
            chk(iss_is_imm == e_imm_f, "R2 R3 operation kind", 32'(iss_is_imm), 32'(e_imm_f));
            if (e_imm_f) begin
                chk(iss_imm == e_imm, "R2 literal value", iss_imm, e_imm);
                if (n_hs == 0) chk(iss_imm == 32'h8080_8080, "R2 example literal", iss_imm, 32'h8080_8080);
            end else begin
                chk(iss_syl == e_syl, "R3 syllable order", 32'(iss_syl), 32'(e_syl));
                chk(iss_syl != 6'b000001, "R5 no-operation skipped", 32'(iss_syl), 32'd0);
            end
            chk(pc == e_pc, "R4 pc", pc, e_pc);
            chk(sc == e_sc, "R4 sc", 32'(sc), 32'(e_sc));
            if (probe_on) begin
                if (probe_cnt == 2) chk((pc == 32'h204) && (sc == 3'd3), "R4 middle slot of 0x200",
                                        {pc[28:0], sc}, {29'h204, 3'd3});
                probe_cnt++;
            end
            n_hs++;
        end
        prev_stall  = iss_valid && !iss_ready;
        prev_syl    = iss_syl;
        prev_imm    = iss_imm;
        prev_is_imm = iss_is_imm;
    endtask

    // instruction memory: answers each request after 1 to 3 cycles
    initial begin
        imem_rsp_valid = 1'b0;
        imem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            imem_rsp_valid = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
            end else if (pend) begin
                if (cnt <= 1) begin
                    imem_rsp_valid = 1'b1;
                    imem_rsp_data  = mem[paddr[11:2]];
                    pend = 1'b0;
                end else begin
                    cnt--;
                end
            end else if (imem_req_valid) begin
                pend  = 1'b1;
                paddr = imem_req_addr;
                cnt   = 1 + int'($urandom % 3);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = gen_word();
        mem[0]   = 32'hC040_4040;
        mem[1]   = {2'b00, 6'b000001, 6'b000001, 6'h2a, 6'b000001, 6'h2b};
        mem[128] = {2'b00, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25};
        mem[512] = 32'h4123_4567;
        mem[528] = {2'b00, 6'h21, 6'b000000, 6'h22, 6'h23, 6'h24};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(imem_req_valid && (imem_req_addr == 32'h0), "R1 reset fetch", imem_req_addr, 32'h0);
        chk(!iss_valid && !halted && !illegal && (sc == 3'd0) && (pc == 32'h0), "R1 reset outputs",
            {iss_valid, halted, illegal, sc, pc[25:0]}, 32'h0);

        // directed: literal example then a word with several no-operations (R2, R5)
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, '0);

        // random stall and redirect mix (R3, R4, R6, R7, R8)
        for (int i = 0; i < 3000; i++) begin
            bit          rv;
            logic [31:0] ra;
            rv = (($urandom % 40) == 0);
            ra = 32'($urandom % 256) << 2;
            step(($urandom % 4) != 0, rv, ra);
        end

        // directed: middle slot of the word at 0x200 (R4)
        probe_on = 1'b1;
        step(1'b1, 1'b1, 32'h200);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, '0);
        probe_on = 1'b0;

        // directed: reserved-format word (R9)
        step(1'b1, 1'b1, 32'h800);
        for (int i = 0; i < 12 && !illegal; i++) step(1'b1, 1'b0, '0);
        chk(illegal, "R9 illegal raised", 32'(illegal), 32'd1);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, '0);
            chk(illegal && !imem_req_valid && !iss_valid, "R9 quiet while illegal",
                {illegal, imem_req_valid, iss_valid}, 3'b100);
        end
        step(1'b1, 1'b1, 32'h10);
        step(1'b1, 1'b0, '0);
        chk(!illegal, "R9 redirect clears illegal", 32'(illegal), 32'd0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0);

        // directed: halt syllable (R10)
        step(1'b1, 1'b1, 32'h840);
        for (int i = 0; i < 20 && !halted; i++) step(1'b1, 1'b0, '0);
        chk(halted && m_halt, "R10 halted after halt syllable", {halted, m_halt}, 2'b11);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, (i % 2) == 0, 32'h0);
            chk(halted && !imem_req_valid && !iss_valid, "R10 redirect ignored after halt",
                {halted, imem_req_valid, iss_valid}, 3'b100);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule